// File: doc/BRIEF.md
# Parity-Protected Partial-Write Merge Unit

This block connects a bus master's write cycles to a main memory in which every 32-bit longword carries one parity bit. Each write arrives with one enable per byte. When every byte is enabled, the longword goes to memory at once with freshly generated parity. When only some bytes are enabled, the block runs a read-modify-write: it reads and holds the old longword, substitutes the enabled new bytes and writes the result back.

The parity of the old longword is checked during the write-back cycle itself, so no separate check step is needed. A failed check does not stop the write. Instead it sets a sticky error flag and records the address of the failing longword. The byte enables are only known once the request has been sampled, so the block does not use ready-based flow control to hold the bus. It asks for a bus-clock stretch, and only for the one cycle that the extra read takes. The memory sits outside the block: it has a combinational read port and a write port that stores on the clock edge.

Top module: `pmerge_unit`

## Requirements
- R1: A write sampled in idle with all four enables set (`wr_be` = 4'b1111) gives exactly one memory write cycle in the next clock cycle. In that cycle `mem_wdata` equals `wr_data`, and `mem_re` and `stretch_req` stay low. `busy` is high for only that one cycle.
- R2: A write with some enables clear and at least one set gives one read cycle (`mem_re`) at the captured address. The next cycle is one write cycle. In the written longword, byte i (bits 8i+7:8i) takes the new data where `wr_be[i]` is 1 and keeps the old data where it is 0.
- R3: Every longword written carries odd parity: the XOR of the 32 `mem_wdata` bits and `mem_wpar` is 1. This holds even when the old longword had bad parity.
- R4: `stretch_req` is high only during the read cycle of a partial write. That is exactly one cycle, and it starts in the cycle after the request is sampled, never in the sampling cycle.
- R5: During the write-back cycle of a partial write, the held old longword and its parity bit are checked for odd parity. On a failure the write still completes, and from the next cycle `perr_flag` is 1 and `perr_addr` holds the write address. Full writes perform no check.
- R6: `perr_flag` stays set until a cycle with `err_clr` high. A parity failure in the same cycle as `err_clr` leaves the flag set.
- R7: A write with `wr_be` = 4'b0000 starts no memory read or write, no stretch, and does not raise `busy`.
- R8: While reset is held and after it is released, the block is idle: `busy`, `mem_re`, `mem_we`, `stretch_req`, `wr_done` and `perr_flag` are 0.
- R9: `wr_valid` is ignored while `busy` is high, so such a request changes no memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request, sampled when not busy |
| wr_addr | input | ADDR_W | Longword address |
| wr_data | input | 32 | New write data |
| wr_be | input | 4 | Per-byte enables, bit i covers byte i |
| busy | output | 1 | A write is in progress |
| stretch_req | output | 1 | Bus-clock stretch request during the extra read |
| wr_done | output | 1 | High in the memory write cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory longword address |
| mem_wdata | output | 32 | Data to memory |
| mem_wpar | output | 1 | Parity bit to memory |
| mem_rdata | input | 32 | Data from memory, combinational read |
| mem_rpar | input | 1 | Parity bit from memory |
| err_clr | input | 1 | Clears the parity error flag |
| perr_flag | output | 1 | Sticky old-data parity error |
| perr_addr | output | ADDR_W | Address of the last failing longword |

## Verification
The assertions check on every clock edge that written parity is odd, and that a stretch is always followed by a write-back and only appears after a sampled request. They also check that a read is always followed by a write, that memory is never touched while idle, and that the error flag holds until cleared. Only the bench scenarios can show the correctness of the merged byte pattern and the final memory image after mixed full and partial writes. The same goes for the recorded error address after injected faults, the precedence of set over clear, and the fact that requests made while busy leave memory untouched.

// File: rtl/pmerge_pkg.sv
package pmerge_pkg;
    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_READ  = 2'd1,
        PM_WRITE = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pmerge_byte_merge.sv
module pmerge_byte_merge #(
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES
) (
    input  logic [DW-1:0]     old_data,
    input  logic [DW-1:0]     new_data,
    input  logic [NBYTES-1:0] be,
    output logic [DW-1:0]     merged
);
    // One lane per byte: take the new byte when its enable is set.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign merged[8*g +: 8] = be[g] ? new_data[8*g +: 8] : old_data[8*g +: 8];
    end
endmodule

// File: rtl/pmerge_parity.sv
module pmerge_parity #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] gen_data,
    output logic          gen_par,
    input  logic [DW-1:0] chk_data,
    input  logic          chk_par,
    output logic          chk_ok
);
    // Odd parity: the data bits and the parity bit XOR to 1.
    assign gen_par = ~(^gen_data);
    assign chk_ok  = ^{chk_data, chk_par};
endmodule

// File: rtl/pmerge_ctrl.sv
module pmerge_ctrl
    import pmerge_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_rpar,
    input  logic              old_ok,
    input  logic              err_clr,
    output logic              busy,
    output logic              stretch_req,
    output logic              wr_done,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     new_q_data,
    output logic [NBYTES-1:0] be_q_out,
    output logic [DW-1:0]     old_q_data,
    output logic              old_q_par,
    output logic              perr_flag,
    output logic [ADDR_W-1:0] perr_addr
);
    typedef struct packed {
        pm_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [NBYTES-1:0] be;
        logic [DW-1:0]     old;
        logic              old_par;
        logic              perr;
        logic [ADDR_W-1:0] perr_addr;
    } ctrl_s;

    ctrl_s q, d;
    logic  partial_q;

    assign partial_q = ~(&q.be);

    always_comb begin
        d = q;
        case (q.st)
            PM_IDLE: begin
                if (wr_valid && (|wr_be)) begin
                    d.addr = wr_addr;
                    d.data = wr_data;
                    d.be   = wr_be;
                    // Stretch decision only after the enables are sampled.
                    d.st   = (&wr_be) ? PM_WRITE : PM_READ;
                end
            end
            PM_READ: begin
                d.old     = mem_rdata;
                d.old_par = mem_rpar;
                d.st      = PM_WRITE;
            end
            PM_WRITE: d.st = PM_IDLE;
            default:  d.st = PM_IDLE;
        endcase
        if (err_clr) d.perr = 1'b0;
        // Old-data check overlaps the merged write-back; set beats clear.
        if (q.st == PM_WRITE && partial_q && !old_ok) begin
            d.perr      = 1'b1;
            d.perr_addr = q.addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != PM_IDLE);
    assign stretch_req = (q.st == PM_READ);
    assign mem_re      = (q.st == PM_READ);
    assign mem_we      = (q.st == PM_WRITE);
    assign wr_done     = (q.st == PM_WRITE);
    assign mem_addr    = q.addr;
    assign new_q_data  = q.data;
    assign be_q_out    = q.be;
    assign old_q_data  = q.old;
    assign old_q_par   = q.old_par;
    assign perr_flag   = q.perr;
    assign perr_addr   = q.perr_addr;

    assert_stretch_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_req |-> $past(wr_valid && !busy));
    assert_stretch_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_req |=> (mem_we && !stretch_req));
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_we && !mem_re));
    assert_idle_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !stretch_req));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !err_clr) |=> perr_flag);
endmodule

// File: rtl/pmerge_unit.sv
module pmerge_unit #(
    parameter int ADDR_W = 10,
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NBYTES-1:0] wr_be,
    output logic              busy,
    output logic              stretch_req,
    output logic              wr_done,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_wpar,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_rpar,
    input  logic              err_clr,
    output logic              perr_flag,
    output logic [ADDR_W-1:0] perr_addr
);
    logic [DW-1:0]     new_data, old_data, merged;
    logic [NBYTES-1:0] be_q;
    logic              old_par, old_ok;

    pmerge_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .mem_rdata(mem_rdata), .mem_rpar(mem_rpar), .old_ok(old_ok), .err_clr(err_clr),
        .busy(busy), .stretch_req(stretch_req), .wr_done(wr_done),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .new_q_data(new_data), .be_q_out(be_q), .old_q_data(old_data), .old_q_par(old_par),
        .perr_flag(perr_flag), .perr_addr(perr_addr)
    );

    // A full write has every enable set, so the merge passes the new data.
    pmerge_byte_merge #(.NBYTES(NBYTES)) merge_i (
        .old_data(old_data), .new_data(new_data), .be(be_q), .merged(merged)
    );

    pmerge_parity #(.DW(DW)) par_i (
        .gen_data(merged), .gen_par(mem_wpar),
        .chk_data(old_data), .chk_par(old_par), .chk_ok(old_ok)
    );

    assign mem_wdata = merged;

    assert_write_parity_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (^{mem_wdata, mem_wpar}));
    assert_done_with_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !mem_we);
endmodule

// File: tb/pmerge_unit_tb_top.sv
module pmerge_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0] wr_be = '0;
    logic err_clr = 1'b0;
    logic busy, stretch_req, wr_done, mem_re, mem_we, mem_wpar, perr_flag;
    logic [AW-1:0] mem_addr, perr_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic mem_rpar;

    logic [32:0] mem [0:(1<<AW)-1];
    logic [32:0] expv [0:(1<<AW)-1];

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmerge_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .busy(busy), .stretch_req(stretch_req), .wr_done(wr_done),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
        .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
        .err_clr(err_clr), .perr_flag(perr_flag), .perr_addr(perr_addr)
    );

    // Behavioural memory: combinational read, write on the clock edge.
    assign mem_rdata = mem[mem_addr][31:0];
    assign mem_rpar  = mem[mem_addr][32];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= {mem_wpar, mem_wdata};

    function automatic logic [31:0] merge_f(input logic [31:0] o, input logic [31:0] n,
                                            input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    function automatic logic oddpar_f(input logic [31:0] v);
        return ~(^v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one write and follow it cycle by cycle.
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] dt, input logic [3:0] be,
                            input bit expect_perr);
        logic [31:0] m;
        wr_valid = 1'b1; wr_addr = a; wr_data = dt; wr_be = be;
        @(negedge clk);
        wr_valid = 1'b0;
        if (be == 4'h0) begin
            chk(!busy && !mem_re && !mem_we && !stretch_req, "R7 no access",
                {busy, mem_re, mem_we, stretch_req}, 0);
            return;
        end
        if (be != 4'hF) begin
            chk(mem_re && stretch_req && !mem_we && mem_addr == a, "R4 stretch in read phase",
                {mem_re, stretch_req, mem_we}, 3'b110);
            @(negedge clk);
        end else begin
            chk(!mem_re && !stretch_req, "R1 full no read/stretch", {mem_re, stretch_req}, 0);
        end
        m = merge_f(expv[a][31:0], dt, be);
        chk(mem_we && wr_done && mem_addr == a, "R1/R2 write cycle", {mem_we, wr_done}, 2'b11);
        chk(mem_wdata == m, (be == 4'hF) ? "R1 full data" : "R2 merged data", mem_wdata, m);
        chk(^{mem_wdata, mem_wpar}, "R3 odd parity", mem_wpar, oddpar_f(m));
        expv[a] = {oddpar_f(m), m};
        @(negedge clk);
        chk(!busy && !mem_we, "R1 back to idle", busy, 0);
        if (expect_perr)
            chk(perr_flag && perr_addr == a, "R5 parity error captured",
                {perr_flag, perr_addr}, {1'b1, a});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        logic [3:0] be;
        logic [31:0] dt;
        int seed_dummy;
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = {1'b1, 32'h0};
            expv[i] = {1'b1, 32'h0};
        end
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_re && !mem_we && !stretch_req && !wr_done && !perr_flag,
            "R8 reset state", {busy, mem_re, mem_we, stretch_req, wr_done, perr_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !perr_flag, "R8 after release", {busy, perr_flag}, 0);

        // Directed: full, partial single byte, partial three bytes, no enables.
        do_write(10'd1, 32'hDEADBEEF, 4'hF, 0);
        do_write(10'd1, 32'h11223344, 4'h2, 0);
        do_write(10'd1, 32'hAABBCCDD, 4'hB, 0);
        do_write(10'd1, 32'h55555555, 4'h0, 0);
        chk(mem[1] == expv[1], "R7 unchanged after empty write", mem[1], expv[1]);

        // Fault on old data: partial write still completes and flags it.
        mem[5] = {1'b1, 32'h00000001};  // even parity: bad
        expv[5] = mem[5];
        do_write(10'd5, 32'hCAFE0000, 4'hC, 1);
        chk(mem[5] == expv[5], "R5 write completes with fresh parity", mem[5], expv[5]);
        do_write(10'd6, 32'h12345678, 4'hF, 0);
        chk(perr_flag && perr_addr == 10'd5, "R6 flag sticky", {perr_flag, perr_addr}, 11'h405);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk(!perr_flag, "R6 cleared", perr_flag, 0);

        // Full write over bad parity: no check.
        mem[7] = {1'b0, 32'h0};
        expv[7] = mem[7];
        do_write(10'd7, 32'h0F0F0F0F, 4'hF, 0);
        chk(!perr_flag, "R5 full write not checked", perr_flag, 0);

        // Set and clear in the same cycle: set wins.
        mem[8] = {1'b0, 32'h0};
        expv[8] = mem[8];
        wr_valid = 1'b1; wr_addr = 10'd8; wr_data = 32'h000000AB; wr_be = 4'h1;
        @(negedge clk); wr_valid = 1'b0;
        @(negedge clk); err_clr = 1'b1;
        expv[8] = {oddpar_f(32'h000000AB), 32'h000000AB};
        @(negedge clk); err_clr = 1'b0;
        chk(perr_flag && perr_addr == 10'd8, "R6 set wins over clear", {perr_flag, perr_addr}, 11'h408);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;

        // Request during busy is ignored.
        wr_valid = 1'b1; wr_addr = 10'd20; wr_data = 32'h99999999; wr_be = 4'h3;
        @(negedge clk);
        wr_addr = 10'd21; wr_data = 32'h77777777; wr_be = 4'hF;
        @(negedge clk);
        expv[20] = {oddpar_f(merge_f(32'h0, 32'h99999999, 4'h3)), merge_f(32'h0, 32'h99999999, 4'h3)};
        wr_valid = 1'b0;
        @(negedge clk);
        chk(!busy, "R9 idle after write", busy, 0);
        chk(mem[21] == expv[21], "R9 busy request ignored", mem[21], expv[21]);
        chk(mem[20] == expv[20], "R2 merged word stored", mem[20], expv[20]);

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            a = AW'($urandom_range(32, 47));
            be = 4'($urandom_range(0, 15));
            dt = $urandom;
            do_write(a, dt, be, 0);
        end
        for (int i = 0; i < 64; i++)
            chk(mem[i] == expv[i], "R2 memory image", mem[i], expv[i]);
        chk(!perr_flag, "R5 no spurious error", perr_flag, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule